// File: doc/BRIEF.md
# Typed Instruction Dispatcher with Completion Barrier

This block takes abstract instructions, one at a time, from an upstream queue over a valid/ready handshake. It holds each one in a single staging slot and waits a programmable number of cycles. It then hands the instruction to a unit chosen by the instruction's kind: a read unit, a write unit or an execute unit. The instruction's subtype picks which unit of that kind receives it. For reads and writes the subtype names a logical FIFO, and for execute it names a processing resource. The subtype and the budget go out on a payload bus shared by all units. Each unit takes work through its own issue valid/ready pair. It reports completion with a one-cycle done pulse that carries its flat unit index.

Instructions that flow in back to back are issued as one group. The group closes when the staged instruction's unit is still busy, or when the queue runs dry while work is outstanding. Once the group is closed, the block stops taking and issuing instructions until every unit of the group has reported done. A relaxed mode lets a staged read go ahead while only execute units are still busy. A peek port shows whether an instruction is staged and what kind it is, without consuming it.

Top module: `instr_dispatcher`

## Requirements
- R1: After synchronous active-high reset, `inReady` is 1, `unitIssueValid` is all zero and `peekAvail` is 0.
- R2: Kind encoding is 00 read, 01 write, 10 or 11 execute. With NR read, NW write and NE execute units, a read goes to flat unit `sub % NR`, a write to `NR + sub % NW`, and an execute to `NR + NW + sub % NE`. At most one bit of `unitIssueValid` is set, and `issueSub`/`issueBudget` carry the staged instruction's fields.
- R3: An instruction accepted at clock edge k with `cfgDelay` = D can first raise its issue valid in the cycle after edge k+D. D = 0 adds no wait.
- R4: From acceptance until its issue handshake completes, `peekAvail` is 1 and `peekKind` holds the staged kind. `inReady` is 0 while an instruction is staged.
- R5: A unit holds at most one outstanding instruction. An instruction whose unit has not yet pulsed done is not issued.
- R6: In strict mode (`cfgRelaxed` = 0), once the group closes on a busy target, nothing is issued or accepted until every busy unit has reported done, even if the target unit itself is already free.
- R7: If no instruction is staged, `inValid` is 0 and some unit is busy at a clock edge, the group closes and `inReady` stays 0 until all units are idle.
- R8: In relaxed mode, a closed group lets input be accepted and a staged read be issued once no read or write unit is busy. A staged write or execute still waits for all units to be idle.
- R9: A done pulse naming a unit that holds no work changes nothing.
- R10: While an issue valid is high and its unit's ready is low, the valid, `issueSub` and `issueBudget` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfgDelay | input | DLY_W | Wait cycles between acceptance and issue |
| cfgRelaxed | input | 1 | 1 lets reads run ahead of busy execute units |
| inValid | input | 1 | Queue head valid |
| inReady | output | 1 | Dispatcher takes the head this cycle |
| inKind | input | 2 | Head instruction kind |
| inSub | input | SUB_W | Head instruction subtype |
| inBudget | input | BUD_W | Head instruction budget |
| peekAvail | output | 1 | An instruction is staged |
| peekKind | output | 2 | Kind of the staged instruction |
| unitIssueValid | output | NU | Per-unit issue valid, one-hot or zero |
| unitIssueReady | input | NU | Per-unit issue ready |
| issueSub | output | SUB_W | Subtype on the shared issue payload |
| issueBudget | output | BUD_W | Budget on the shared issue payload |
| doneValid | input | 1 | Completion pulse |
| doneIdx | input | UIDX_W | Flat index of the completing unit |

## Verification
The bench aims at the barrier cases. A read is queued behind a read unit that is still busy while an execute is also outstanding, and the execute's done must release it. A design that waited only for the target unit would issue early there. Relaxed mode is run through the same pattern, plus a write that must still wait for the execute. A dispatcher that treated all kinds alike would either block the read or leak the write. Further cases are a dry queue that must close the group, a stray done for an idle unit (a bad index decode would free the wrong unit), a held issue against a stalled unit, the delay count for zero and non-zero values, and the modulo routing of every kind, including the spare execute code.

// File: rtl/disp_pkg.sv
package disp_pkg;

  typedef enum logic [1:0] {
    KIND_READ     = 2'b00,
    KIND_WRITE    = 2'b01,
    KIND_EXEC     = 2'b10,
    KIND_EXEC_ALT = 2'b11
  } kind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;
    logic issueReq;
    logic issueFire;
  } ctl_t;

endpackage

// File: rtl/disp_dpath.sv
module disp_dpath
  import disp_pkg::*;
#(
  parameter int NR     = 2,
  parameter int NW     = 2,
  parameter int NE     = 2,
  parameter int SUB_W  = 4,
  parameter int BUD_W  = 8,
  parameter int DLY_W  = 4,
  localparam int NU     = NR + NW + NE,
  localparam int UIDX_W = $clog2(NU)
) (
  input  logic              clk,
  input  logic              rst,
  input  ctl_t              ctl,
  input  logic [DLY_W-1:0]  cfgDelay,
  input  logic [1:0]        inKind,
  input  logic [SUB_W-1:0]  inSub,
  input  logic [BUD_W-1:0]  inBudget,
  input  logic              doneValid,
  input  logic [UIDX_W-1:0] doneIdx,
  output logic              stgValid,
  output kind_e             stgKind,
  output logic              stgIsRead,
  output logic [SUB_W-1:0]  stgSub,
  output logic [BUD_W-1:0]  stgBudget,
  output logic              delayDone,
  output logic [UIDX_W-1:0] target,
  output logic [NU-1:0]     busy,
  output logic [NU-1:0]     issueVec
);

  logic [DLY_W-1:0] waitCnt;
  logic [NU-1:0]    busyNext;
  logic [31:0]      subWide;
  logic [31:0]      tgtWide;

  // staging slot
  always_ff @(posedge clk) begin
    if (rst) begin
      stgValid  <= 1'b0;
      stgKind   <= KIND_READ;
      stgSub    <= '0;
      stgBudget <= '0;
    end else if (ctl.accept) begin
      stgValid  <= 1'b1;
      stgKind   <= kind_e'(inKind);
      stgSub    <= inSub;
      stgBudget <= inBudget;
    end else if (ctl.issueFire) begin
      stgValid  <= 1'b0;
    end
  end

  // programmable wait between acceptance and issue
  always_ff @(posedge clk) begin
    if (rst)
      waitCnt <= '0;
    else if (ctl.accept)
      waitCnt <= cfgDelay;
    else if (stgValid && waitCnt != '0)
      waitCnt <= waitCnt - 1'b1;
  end

  assign delayDone = (waitCnt == '0);
  assign stgIsRead = (stgKind == KIND_READ);

  // kind plus subtype to flat unit index
  always_comb begin
    subWide = 32'(stgSub);
    case (stgKind)
      KIND_READ:  tgtWide = subWide % NR;
      KIND_WRITE: tgtWide = NR + (subWide % NW);
      default:    tgtWide = NR + NW + (subWide % NE);
    endcase
    target = UIDX_W'(tgtWide);
  end

  // outstanding-work bitmap
  always_comb begin
    busyNext = busy;
    if (doneValid && (32'(doneIdx) < NU))
      busyNext[doneIdx] = 1'b0;
    if (ctl.issueFire)
      busyNext[target] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) busy <= '0;
    else     busy <= busyNext;
  end

  always_comb begin
    issueVec = '0;
    if (ctl.issueReq)
      issueVec[target] = 1'b1;
  end

endmodule

// File: rtl/disp_ctrl.sv
module disp_ctrl
  import disp_pkg::*;
#(
  parameter int NR = 2,
  parameter int NW = 2,
  parameter int NE = 2,
  localparam int NU     = NR + NW + NE,
  localparam int UIDX_W = $clog2(NU)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgRelaxed,
  input  logic              inValid,
  input  logic              stgValid,
  input  logic              stgIsRead,
  input  logic              delayDone,
  input  logic [UIDX_W-1:0] target,
  input  logic [NU-1:0]     busy,
  input  logic [NU-1:0]     unitIssueReady,
  output logic              inReady,
  output ctl_t              ctl
);

  // read and write units occupy the low flat indices
  localparam logic [NU-1:0] RW_MASK = NU'((64'd1 << (NR + NW)) - 64'd1);

  logic closed;
  logic allIdle;
  logic rwIdle;
  logic targetBusy;
  logic releaseOk;
  logic closeOnBusy;
  logic closeOnDry;

  assign allIdle    = (busy == '0);
  assign rwIdle     = ((busy & RW_MASK) == '0);
  assign targetBusy = busy[target];

  assign releaseOk = allIdle | (cfgRelaxed & stgIsRead & rwIdle);

  always_comb begin
    ctl.issueReq  = stgValid & delayDone & ~targetBusy & (~closed | releaseOk);
    ctl.issueFire = ctl.issueReq & unitIssueReady[target];
    inReady       = ~stgValid & (~closed | allIdle | (cfgRelaxed & rwIdle));
    ctl.accept    = inValid & inReady;
  end

  assign closeOnBusy = stgValid & delayDone & targetBusy;
  assign closeOnDry  = ~stgValid & ~inValid & ~allIdle;

  always_ff @(posedge clk) begin
    if (rst) closed <= 1'b0;
    else     closed <= (closed & ~allIdle) | closeOnBusy | closeOnDry;
  end

endmodule

// File: rtl/instr_dispatcher.sv
module instr_dispatcher
  import disp_pkg::*;
#(
  parameter int NR     = 2,
  parameter int NW     = 2,
  parameter int NE     = 2,
  parameter int SUB_W  = 4,
  parameter int BUD_W  = 8,
  parameter int DLY_W  = 4,
  localparam int NU     = NR + NW + NE,
  localparam int UIDX_W = $clog2(NU)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DLY_W-1:0]  cfgDelay,
  input  logic              cfgRelaxed,
  input  logic              inValid,
  output logic              inReady,
  input  logic [1:0]        inKind,
  input  logic [SUB_W-1:0]  inSub,
  input  logic [BUD_W-1:0]  inBudget,
  output logic              peekAvail,
  output logic [1:0]        peekKind,
  output logic [NU-1:0]     unitIssueValid,
  input  logic [NU-1:0]     unitIssueReady,
  output logic [SUB_W-1:0]  issueSub,
  output logic [BUD_W-1:0]  issueBudget,
  input  logic              doneValid,
  input  logic [UIDX_W-1:0] doneIdx
);

  ctl_t              ctl;
  logic              stgValid;
  kind_e             stgKind;
  logic              stgIsRead;
  logic              delayDone;
  logic [UIDX_W-1:0] target;
  logic [NU-1:0]     busy;

  disp_ctrl #(.NR(NR), .NW(NW), .NE(NE)) u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .cfgRelaxed     (cfgRelaxed),
    .inValid        (inValid),
    .stgValid       (stgValid),
    .stgIsRead      (stgIsRead),
    .delayDone      (delayDone),
    .target         (target),
    .busy           (busy),
    .unitIssueReady (unitIssueReady),
    .inReady        (inReady),
    .ctl            (ctl)
  );

  disp_dpath #(
    .NR(NR), .NW(NW), .NE(NE), .SUB_W(SUB_W), .BUD_W(BUD_W), .DLY_W(DLY_W)
  ) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .cfgDelay  (cfgDelay),
    .inKind    (inKind),
    .inSub     (inSub),
    .inBudget  (inBudget),
    .doneValid (doneValid),
    .doneIdx   (doneIdx),
    .stgValid  (stgValid),
    .stgKind   (stgKind),
    .stgIsRead (stgIsRead),
    .stgSub    (issueSub),
    .stgBudget (issueBudget),
    .delayDone (delayDone),
    .target    (target),
    .busy      (busy),
    .issueVec  (unitIssueValid)
  );

  assign peekAvail = stgValid;
  assign peekKind  = stgKind;

endmodule

// File: rtl/disp_chk.sv
module disp_chk #(
  parameter int NR     = 2,
  parameter int NW     = 2,
  parameter int NE     = 2,
  parameter int SUB_W  = 4,
  parameter int BUD_W  = 8,
  parameter int DLY_W  = 4,
  localparam int NU     = NR + NW + NE,
  localparam int UIDX_W = $clog2(NU)
) (
  input logic              clk,
  input logic              rst,
  input logic [DLY_W-1:0]  cfgDelay,
  input logic              cfgRelaxed,
  input logic              inValid,
  input logic              inReady,
  input logic [1:0]        inKind,
  input logic [SUB_W-1:0]  inSub,
  input logic [BUD_W-1:0]  inBudget,
  input logic              peekAvail,
  input logic [1:0]        peekKind,
  input logic [NU-1:0]     unitIssueValid,
  input logic [NU-1:0]     unitIssueReady,
  input logic [SUB_W-1:0]  issueSub,
  input logic [BUD_W-1:0]  issueBudget,
  input logic              doneValid,
  input logic [UIDX_W-1:0] doneIdx
);

  logic [NU-1:0] shadowBusy;
  logic [NU-1:0] shadowNext;
  logic          anyFire;

  assign anyFire = |(unitIssueValid & unitIssueReady);

  // unit occupancy rebuilt from port handshakes only
  always_comb begin
    shadowNext = shadowBusy;
    if (doneValid && (32'(doneIdx) < NU))
      shadowNext[doneIdx] = 1'b0;
    shadowNext = shadowNext | (unitIssueValid & unitIssueReady);
  end

  always_ff @(posedge clk) begin
    if (rst) shadowBusy <= '0;
    else     shadowBusy <= shadowNext;
  end

  p_onehot_issue_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(unitIssueValid));

  p_no_busy_issue_r5: assert property (@(posedge clk) disable iff (rst)
    (unitIssueValid & shadowBusy) == '0);

  p_hold_issue_r10: assert property (@(posedge clk) disable iff (rst)
    (|(unitIssueValid & ~unitIssueReady)) |=>
      (unitIssueValid == $past(unitIssueValid)) && $stable(issueSub) && $stable(issueBudget));

  p_peek_held_r4: assert property (@(posedge clk) disable iff (rst)
    (peekAvail && !anyFire) |=> (peekAvail && $stable(peekKind)));

  p_stage_blocks_input_r4: assert property (@(posedge clk) disable iff (rst)
    peekAvail |-> !inReady);

  p_accept_stages_r4: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) |=> peekAvail);

endmodule

bind instr_dispatcher disp_chk #(
  .NR(NR), .NW(NW), .NE(NE), .SUB_W(SUB_W), .BUD_W(BUD_W), .DLY_W(DLY_W)
) u_chk (.*);

// File: tb/sim_instr_dispatcher.sv
`timescale 1ns/1ps
module sim_instr_dispatcher;

  localparam int NR = 2, NW = 2, NE = 2, SUB_W = 4, BUD_W = 8, DLY_W = 4;
  localparam int NU = NR + NW + NE;
  localparam int UIDX_W = $clog2(NU);
  localparam logic [1:0] K_RD = 2'b00, K_WR = 2'b01, K_EX = 2'b10, K_EX2 = 2'b11;

  logic              clk = 1'b0;
  logic              rst;
  logic [DLY_W-1:0]  cfgDelay;
  logic              cfgRelaxed;
  logic              inValid;
  logic              inReady;
  logic [1:0]        inKind;
  logic [SUB_W-1:0]  inSub;
  logic [BUD_W-1:0]  inBudget;
  logic              peekAvail;
  logic [1:0]        peekKind;
  logic [NU-1:0]     unitIssueValid;
  logic [NU-1:0]     unitIssueReady;
  logic [SUB_W-1:0]  issueSub;
  logic [BUD_W-1:0]  issueBudget;
  logic              doneValid;
  logic [UIDX_W-1:0] doneIdx;

  int nChecks = 0;
  int nFails  = 0;
  bit summaryDone = 0;

  always #4 clk = ~clk;

  instr_dispatcher #(
    .NR(NR), .NW(NW), .NE(NE), .SUB_W(SUB_W), .BUD_W(BUD_W), .DLY_W(DLY_W)
  ) u0 (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input longint actual, input longint expected);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
    end
  endtask

  // caller stands at a negedge; returns at the negedge after acceptance
  task automatic push(input logic [1:0] k, input int sub, input int bud);
    inValid  = 1'b1;
    inKind   = k;
    inSub    = SUB_W'(sub);
    inBudget = BUD_W'(bud);
    for (int i = 0; i < 1000; i++) begin
      #1;
      if (inReady) begin
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    inValid = 1'b0;
  endtask

  // waits for an issue, checks it, returns at the negedge after the handshake
  task automatic expectIssue(input int unit, input int sub, input int bud,
                             input string req, output int waited);
    waited = 0;
    for (int i = 0; i < 40; i++) begin
      #1;
      if (unitIssueValid != '0) break;
      @(negedge clk);
      waited++;
    end
    check(unitIssueValid == (NU'(1) << unit), req, "issue vector",
          unitIssueValid, NU'(1) << unit);
    check(issueSub == SUB_W'(sub) && issueBudget == BUD_W'(bud), req, "payload sub*256+budget",
          issueSub * 256 + issueBudget, sub * 256 + bud);
    @(negedge clk);
  endtask

  task automatic expectQuiet(input int cycles, input string req);
    bit quiet = 1;
    for (int i = 0; i < cycles; i++) begin
      #1;
      if (unitIssueValid != '0) quiet = 0;
      @(negedge clk);
    end
    check(quiet, req, "no issue while blocked", quiet, 1);
  endtask

  task automatic pulseDone(input int idx);
    doneValid = 1'b1;
    doneIdx   = UIDX_W'(idx);
    @(negedge clk);
    doneValid = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    check(inReady == 1'b1, "R1", "inReady", inReady, 1);
    check(unitIssueValid == '0, "R1", "issue valid", unitIssueValid, 0);
    check(peekAvail == 1'b0, "R1", "peekAvail", peekAvail, 0);
    @(negedge clk);
  endtask

  task automatic t_routing;
    int w;
    push(K_RD, 5, 11);  expectIssue(1, 5, 11, "R2", w);
    check(w == 0, "R3", "zero delay wait", w, 0);
    pulseDone(1);
    push(K_WR, 2, 12);  expectIssue(2, 2, 12, "R2", w);  pulseDone(2);
    push(K_WR, 3, 13);  expectIssue(3, 3, 13, "R2", w);  pulseDone(3);
    push(K_EX, 7, 14);  expectIssue(5, 7, 14, "R2", w);  pulseDone(5);
    push(K_EX2, 0, 15); expectIssue(4, 0, 15, "R2", w);  pulseDone(4);
  endtask

  task automatic t_peek_hold;
    int w;
    bit good = 1;
    unitIssueReady[0] = 1'b0;
    push(K_RD, 0, 4);
    for (int i = 0; i < 3; i++) begin
      #1;
      if (!(peekAvail && peekKind == K_RD && unitIssueValid == NU'(1)
            && issueSub == '0 && issueBudget == 8'd4)) good = 0;
      @(negedge clk);
    end
    check(good, "R4", "peek and payload held while stalled", good, 1);
    check(good, "R10", "issue held while ready low", good, 1);
    unitIssueReady[0] = 1'b1;
    #1;
    check(unitIssueValid == NU'(1), "R10", "valid still high", unitIssueValid, 1);
    @(negedge clk);
    #1;
    check(peekAvail == 1'b0, "R4", "peek cleared after handshake", peekAvail, 0);
    @(negedge clk);
    pulseDone(0);
  endtask

  task automatic t_delay;
    int w;
    cfgDelay = 4'd3;
    push(K_EX, 0, 6);
    expectIssue(4, 0, 6, "R3", w);
    check(w == 3, "R3", "wait cycles", w, 3);
    cfgDelay = '0;
    pulseDone(4);
  endtask

  task automatic t_barrier(input bit relaxed);
    int w;
    cfgRelaxed = relaxed;
    push(K_RD, 0, 1);
    push(K_EX, 0, 2);
    push(K_RD, 2, 3);
    expectQuiet(3, "R5");
    pulseDone(0);
    if (!relaxed) begin
      expectQuiet(3, "R6");
      pulseDone(4);
      expectIssue(0, 2, 3, "R6", w);
      pulseDone(0);
    end else begin
      expectIssue(0, 2, 3, "R8", w);
      pulseDone(0);
      push(K_WR, 0, 5);
      expectQuiet(3, "R8");
      pulseDone(4);
      expectIssue(2, 0, 5, "R8", w);
      pulseDone(2);
    end
    cfgRelaxed = 1'b0;
  endtask

  task automatic t_dry_queue;
    int w;
    bit blocked = 1;
    push(K_RD, 1, 7);
    expectIssue(1, 1, 7, "R7", w);
    @(negedge clk);
    inValid = 1'b1; inKind = K_EX; inSub = 4'd1; inBudget = 8'd8;
    for (int i = 0; i < 3; i++) begin
      #1;
      if (inReady) blocked = 0;
      @(negedge clk);
    end
    check(blocked, "R7", "input held off after dry queue", blocked, 1);
    pulseDone(1);
    push(K_EX, 1, 8);
    expectIssue(5, 1, 8, "R7", w);
    pulseDone(5);
  endtask

  task automatic t_stray_done;
    int w;
    bit blocked = 1;
    push(K_RD, 0, 9);
    expectIssue(0, 0, 9, "R9", w);
    @(negedge clk);
    pulseDone(1);
    inValid = 1'b1; inKind = K_RD; inSub = 4'd2; inBudget = 8'd10;
    for (int i = 0; i < 2; i++) begin
      #1;
      if (inReady || unitIssueValid != '0) blocked = 0;
      @(negedge clk);
    end
    check(blocked, "R9", "stray done left unit 0 busy", blocked, 1);
    pulseDone(0);
    push(K_RD, 2, 10);
    expectIssue(0, 2, 10, "R9", w);
    pulseDone(0);
  endtask

  task automatic finishRun;
    if (!summaryDone) begin
      summaryDone = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    rst = 1'b1; cfgDelay = '0; cfgRelaxed = 1'b0;
    inValid = 1'b0; inKind = '0; inSub = '0; inBudget = '0;
    unitIssueReady = '1; doneValid = 1'b0; doneIdx = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_routing();
    t_peek_hold();
    t_delay();
    t_barrier(1'b0);
    t_barrier(1'b1);
    t_dry_queue();
    t_stray_done();
    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule